// File: doc/BRIEF.md
# Serial NOR Flash Operation Sequencer

This block turns one host request into the complete series of SPI frames that a serial NOR flash needs for that operation. The supported operations are read, page program, 4 KiB sector erase, whole-chip erase, security-register read, power-down and wake-up. The block controls chip select directly. It hands every byte to a separate bit shifter through a start/done byte handshake. Read data goes back to the host as a valid/ready byte stream, and program data arrives the same way.

Each program or erase is preceded by a write-enable frame on its own, followed by a settle gap with chip select high. After the main command, the block reads the status byte at a fixed interval until the busy bit clears or a per-operation poll budget runs out. A security-register read is checked against the allowed address windows before anything is sent. Its length is clipped at the end of the register, and the block reports how many bytes it actually moved.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `req_ready` is 1, `busy` is 0, and `done`, `rd_valid` and `bx_start` are 0.
- R2: For a read (`req_op`=0), the block sends one frame: 0x03, then address bits [23:16], [15:8] and [7:0], then `req_len` filler bytes of 0x00. Each byte received during the filler phase is delivered in order on `rd_data` and held until `rd_ready`. `done` then reports `xfer_count`=`req_len` and `err`=0.
- R3: For a page program (`req_op`=1), the block sends a frame holding only 0x06, then keeps `cs_n` high for at least SETTLE_CYC cycles. It then sends 0x02, the three address bytes and the write-stream bytes. The byte count is clipped to 256 minus address bits [7:0] and reported in `xfer_count`.
- R4: A sector erase (`req_op`=2) sends 0x06 alone, then 0x20 with the three address bytes. A chip erase (`req_op`=3) sends 0x06 alone, then 0x C7 alone.
- R5: After the main frame of a program or erase, the block sends status frames of 0x05 then 0x00, each starting at least POLL_CYC cycles after the previous frame ends. It stops with `err`=0 at the first status byte whose bit 0 is 0.
- R6: If PAGE_POLLS status bytes in a row show bit 0 set (program and sector erase), or CHIP_POLLS do (chip erase), the block sends no further frame and ends with `err`=1.
- R7: A security-register read (`req_op`=4) sends 0x48, the three address bytes, one 0x00 dummy byte, then N filler bytes. N is `req_len`, but when offset (address bits [7:0]) plus `req_len` exceeds 255, N is 255 minus the offset. Received bytes are delivered and `xfer_count`=N.
- R8: A security-register read whose address bits [13:12] are 0, or whose bits [15:14] or [11:8] are not zero, sends no frame. It ends with `err`=1 and `xfer_count`=0.
- R9: Power-down (`req_op`=5) sends the single-byte frame 0xB9, and wake-up (`req_op`=6) sends the single-byte frame 0xAB.
- R10: A byte is started only while `cs_n` is 0, with at most one byte outstanding. Between any two frames, `cs_n` stays high for at least GAP_CYC cycles.
- R11: From acceptance until `done`, `busy` is 1 and `req_ready` is 0, and a request offered in that time has no effect.
- R12: The request code 7 is refused: no frame is sent, and `done` comes with `err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code (0..6) |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W | Requested byte count |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data byte available |
| wr_ready | output | 1 | Program data byte taken this cycle |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Host takes the received byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error status, valid with done |
| xfer_count | output | LEN_W | Data bytes moved, valid with done |
| busy | output | 1 | Operation in progress |
| cs_n | output | 1 | Flash chip select, active low |
| bx_start | output | 1 | Start one byte on the shifter |
| bx_tx | output | 8 | Byte to shift out |
| bx_done | input | 1 | Shifter finished the byte |
| bx_rx | input | 8 | Byte shifted in |

## Verification
Every frame's bytes, length, start cycle and end cycle are captured at the shifter side. Only the order and content of bytes are compared exactly. Gaps, including the settle gap and the poll interval, are checked as minimum distances between the recorded end of one frame and the start of the next, because the internal timer adds a fixed two-cycle margin. Completion results (`err`, `xfer_count`) are sampled on the falling edge in the one cycle that `done` is high. Read bytes are collected only in cycles where the bench has raised `rd_ready` and `rd_valid` is high, so a random back-pressure pattern does not disturb the comparison.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_SECT  = 3'd2;
  localparam logic [2:0] OP_CHIP  = 3'd3;
  localparam logic [2:0] OP_SREG  = 3'd4;
  localparam logic [2:0] OP_SLEEP = 3'd5;
  localparam logic [2:0] OP_WAKE  = 3'd6;

  localparam logic [7:0] FL_READ  = 8'h03;
  localparam logic [7:0] FL_PROG  = 8'h02;
  localparam logic [7:0] FL_STAT  = 8'h05;
  localparam logic [7:0] FL_WREN  = 8'h06;
  localparam logic [7:0] FL_SECT  = 8'h20;
  localparam logic [7:0] FL_SREG  = 8'h48;
  localparam logic [7:0] FL_WAKE  = 8'hAB;
  localparam logic [7:0] FL_SLEEP = 8'hB9;
  localparam logic [7:0] FL_CHIP  = 8'hC7;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_SETTLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_RDOUT,
    S_ENDF, S_POLLWAIT, S_STAT, S_GAPEND, S_FIN
  } seq_state_e;
endpackage

// File: rtl/nor_req_check.sv
module nor_req_check
  import nor_seq_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int POLL_W     = 8,
  parameter int PAGE_POLLS = 100,
  parameter int CHIP_POLLS = 200
) (
  input  logic [2:0]        op,
  input  logic [23:0]       addr,
  input  logic [LEN_W-1:0]  len,
  output logic              ok,
  output logic [7:0]        opcode,
  output logic              need_wren,
  output logic              has_addr,
  output logic              has_dummy,
  output logic              is_rd,
  output logic              is_wr,
  output logic [LEN_W-1:0]  eff_len,
  output logic [POLL_W-1:0] poll_limit
);
  logic [LEN_W-1:0] page_room;
  logic [LEN_W:0]   sreg_end;
  logic             sreg_win_ok;

  assign page_room   = LEN_W'(256) - LEN_W'(addr[7:0]);
  assign sreg_end    = {1'b0, len} + (LEN_W+1)'(addr[7:0]);
  assign sreg_win_ok = (addr[13:12] != 2'd0) && (addr[15:14] == 2'd0) && (addr[11:8] == 4'd0);

  always_comb begin
    ok = 1'b1; opcode = 8'h00; need_wren = 1'b0; has_addr = 1'b0;
    has_dummy = 1'b0; is_rd = 1'b0; is_wr = 1'b0; eff_len = '0;
    poll_limit = POLL_W'(PAGE_POLLS);
    case (op)
      OP_READ: begin
        opcode = FL_READ; has_addr = 1'b1; is_rd = 1'b1; eff_len = len;
      end
      OP_PROG: begin
        opcode = FL_PROG; need_wren = 1'b1; has_addr = 1'b1; is_wr = 1'b1;
        eff_len = (len > page_room) ? page_room : len;
      end
      OP_SECT: begin
        opcode = FL_SECT; need_wren = 1'b1; has_addr = 1'b1;
      end
      OP_CHIP: begin
        opcode = FL_CHIP; need_wren = 1'b1; poll_limit = POLL_W'(CHIP_POLLS);
      end
      OP_SREG: begin
        opcode = FL_SREG; has_addr = 1'b1; has_dummy = 1'b1; is_rd = 1'b1;
        ok = sreg_win_ok;
        eff_len = (sreg_end > (LEN_W+1)'(255)) ? (LEN_W'(255) - LEN_W'(addr[7:0])) : len;
      end
      OP_SLEEP: opcode = FL_SLEEP;
      OP_WAKE:  opcode = FL_WAKE;
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/nor_countdown.sv
module nor_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         fire
);
  logic [W-1:0] cnt;
  logic         run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      run  <= 1'b0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt <= val;
        run <= 1'b1;
      end else if (run) begin
        if (cnt <= W'(1)) begin
          run  <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int GAP_CYC    = 16,
  parameter int SETTLE_CYC = 625,
  parameter int POLL_CYC   = 62500,
  parameter int PAGE_POLLS = 1000,
  parameter int CHIP_POLLS = 400000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             err,
  output logic [LEN_W-1:0] xfer_count,
  output logic             busy,
  output logic             cs_n,
  output logic             bx_start,
  output logic [7:0]       bx_tx,
  input  logic             bx_done,
  input  logic [7:0]       bx_rx
);
  localparam int TMR_A   = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
  localparam int TMR_MAX = (TMR_A > GAP_CYC) ? TMR_A : GAP_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int POLL_W  = $clog2(((PAGE_POLLS > CHIP_POLLS) ? PAGE_POLLS : CHIP_POLLS) + 1);

  seq_state_e        state;
  logic              c_ok, c_wren, c_addr, c_dummy, c_rd, c_wr;
  logic [7:0]        c_opcode;
  logic [LEN_W-1:0]  c_eff;
  logic [POLL_W-1:0] c_limit;

  logic [7:0]        opcode_q;
  logic              wren_q, addr_q_en, dummy_q, rd_q, wr_q, fail_q, inflight;
  logic [23:0]       addr_q;
  logic [LEN_W-1:0]  eff_q, cnt_q;
  logic [POLL_W-1:0] limit_q, poll_q;
  logic [1:0]        idx_q;
  logic              stat_ix;
  logic              tmr_load, tmr_fire;
  logic [TMR_W-1:0]  tmr_val;
  logic [7:0]        addr_byte;

  nor_req_check #(
    .LEN_W(LEN_W), .POLL_W(POLL_W), .PAGE_POLLS(PAGE_POLLS), .CHIP_POLLS(CHIP_POLLS)
  ) u_check (
    .op(req_op), .addr(req_addr), .len(req_len), .ok(c_ok), .opcode(c_opcode),
    .need_wren(c_wren), .has_addr(c_addr), .has_dummy(c_dummy), .is_rd(c_rd),
    .is_wr(c_wr), .eff_len(c_eff), .poll_limit(c_limit)
  );

  nor_countdown #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .val(tmr_val), .fire(tmr_fire)
  );

  always_comb begin
    case (idx_q)
      2'd0:    addr_byte = addr_q[23:16];
      2'd1:    addr_byte = addr_q[15:8];
      default: addr_byte = addr_q[7:0];
    endcase
  end

  assign wr_ready = (state == S_DATA) && wr_q && !inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; req_ready <= 1'b1; busy <= 1'b0; cs_n <= 1'b1;
      bx_start <= 1'b0; bx_tx <= 8'h00; rd_data <= 8'h00; rd_valid <= 1'b0;
      done <= 1'b0; err <= 1'b0; xfer_count <= '0; inflight <= 1'b0;
      opcode_q <= 8'h00; wren_q <= 1'b0; addr_q_en <= 1'b0; dummy_q <= 1'b0;
      rd_q <= 1'b0; wr_q <= 1'b0; fail_q <= 1'b0; addr_q <= '0; eff_q <= '0;
      cnt_q <= '0; limit_q <= '0; poll_q <= '0; idx_q <= 2'd0; stat_ix <= 1'b0;
      tmr_load <= 1'b0; tmr_val <= '0;
    end else begin
      bx_start <= 1'b0;
      done     <= 1'b0;
      tmr_load <= 1'b0;
      case (state)
        S_IDLE: if (req_valid && req_ready) begin
          req_ready <= 1'b0; busy <= 1'b1; err <= 1'b0; xfer_count <= '0;
          opcode_q <= c_opcode; wren_q <= c_wren; addr_q_en <= c_addr;
          dummy_q <= c_dummy; rd_q <= c_rd; wr_q <= c_wr; addr_q <= req_addr;
          eff_q <= c_eff; limit_q <= c_limit; cnt_q <= '0; poll_q <= '0;
          idx_q <= 2'd0; fail_q <= !c_ok;
          state <= !c_ok ? S_FIN : (c_wren ? S_WREN : S_CMD);
        end
        S_WREN: if (!inflight) begin
          cs_n <= 1'b0; bx_start <= 1'b1; bx_tx <= FL_WREN; inflight <= 1'b1;
        end else if (bx_done) begin
          inflight <= 1'b0; cs_n <= 1'b1; tmr_load <= 1'b1;
          tmr_val <= TMR_W'(SETTLE_CYC); state <= S_SETTLE;
        end
        S_SETTLE: if (tmr_fire) state <= S_CMD;
        S_CMD: if (!inflight) begin
          cs_n <= 1'b0; bx_start <= 1'b1; bx_tx <= opcode_q; inflight <= 1'b1;
        end else if (bx_done) begin
          inflight <= 1'b0; idx_q <= 2'd0;
          state <= addr_q_en ? S_ADDR : S_ENDF;
        end
        S_ADDR: if (!inflight) begin
          bx_start <= 1'b1; bx_tx <= addr_byte; inflight <= 1'b1;
        end else if (bx_done) begin
          inflight <= 1'b0; idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd2) begin
            if (dummy_q) state <= S_DUMMY;
            else if ((rd_q || wr_q) && eff_q != '0) state <= S_DATA;
            else state <= S_ENDF;
          end
        end
        S_DUMMY: if (!inflight) begin
          bx_start <= 1'b1; bx_tx <= 8'h00; inflight <= 1'b1;
        end else if (bx_done) begin
          inflight <= 1'b0;
          state <= (eff_q != '0) ? S_DATA : S_ENDF;
        end
        S_DATA: if (!inflight) begin
          if (wr_q) begin
            if (wr_valid) begin
              bx_start <= 1'b1; bx_tx <= wr_data; inflight <= 1'b1;
            end
          end else begin
            bx_start <= 1'b1; bx_tx <= 8'h00; inflight <= 1'b1;
          end
        end else if (bx_done) begin
          inflight <= 1'b0; cnt_q <= cnt_q + 1'b1;
          if (rd_q) begin
            rd_data <= bx_rx; rd_valid <= 1'b1; state <= S_RDOUT;
          end else if (cnt_q + 1'b1 == eff_q) begin
            state <= S_ENDF;
          end
        end
        S_RDOUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          state <= (cnt_q == eff_q) ? S_ENDF : S_DATA;
        end
        S_ENDF: begin
          cs_n <= 1'b1; tmr_load <= 1'b1;
          if (wren_q) begin
            tmr_val <= TMR_W'(POLL_CYC); state <= S_POLLWAIT;
          end else begin
            tmr_val <= TMR_W'(GAP_CYC); state <= S_GAPEND;
          end
        end
        S_POLLWAIT: if (tmr_fire) begin
          stat_ix <= 1'b0; state <= S_STAT;
        end
        S_STAT: if (!inflight) begin
          cs_n <= 1'b0; bx_start <= 1'b1; inflight <= 1'b1;
          bx_tx <= stat_ix ? 8'h00 : FL_STAT;
        end else if (bx_done) begin
          inflight <= 1'b0;
          if (!stat_ix) begin
            stat_ix <= 1'b1;
          end else begin
            cs_n <= 1'b1; tmr_load <= 1'b1; poll_q <= poll_q + 1'b1;
            if (!bx_rx[0]) begin
              tmr_val <= TMR_W'(GAP_CYC); state <= S_GAPEND;
            end else if (poll_q + 1'b1 >= limit_q) begin
              fail_q <= 1'b1; tmr_val <= TMR_W'(GAP_CYC); state <= S_GAPEND;
            end else begin
              tmr_val <= TMR_W'(POLL_CYC); state <= S_POLLWAIT;
            end
          end
        end
        S_GAPEND: if (tmr_fire) state <= S_FIN;
        S_FIN: begin
          done <= 1'b1; err <= fail_q; xfer_count <= cnt_q;
          busy <= 1'b0; req_ready <= 1'b1; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int GAP_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       bx_start,
  input logic       bx_done,
  input logic       busy,
  input logic       req_ready,
  input logic       done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  int   hi_cnt;
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= GAP_CYC;
      pend   <= 1'b0;
    end else begin
      if (!cs_n) hi_cnt <= 0;
      else if (hi_cnt < GAP_CYC) hi_cnt <= hi_cnt + 1;
      if (bx_start) pend <= 1'b1;
      else if (bx_done) pend <= 1'b0;
    end
  end

  AST_BYTE_IN_FRAME: assert property (@(posedge clk) disable iff (rst) bx_start |-> !cs_n); // R10
  AST_ONE_BYTE_PENDING: assert property (@(posedge clk) disable iff (rst) bx_start |-> !pend); // R10
  AST_CS_HIGH_GAP: assert property (@(posedge clk) disable iff (rst) $fell(cs_n) |-> hi_cnt >= GAP_CYC); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R2
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (rst) req_ready |-> cs_n); // R11
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst) busy |-> !req_ready); // R11
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (rst) done |-> (cs_n && !pend)); // R10
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .bx_start(bx_start), .bx_done(bx_done),
  .busy(busy), .req_ready(req_ready), .done(done), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int LEN_W = 12, GAP = 2, SETTLE = 6, POLL = 10, PPOLL = 4, CPOLL = 7;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0] wr_data = 8'h00;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 1'b0;
  logic done, err, busy, cs_n, bx_start;
  logic [LEN_W-1:0] xfer_count;
  logic [7:0] bx_tx;
  logic bx_done = 1'b0;
  logic [7:0] bx_rx = 8'h00;

  always #4 clk = ~clk;

  nor_cmd_seq #(.LEN_W(LEN_W), .GAP_CYC(GAP), .SETTLE_CYC(SETTLE), .POLL_CYC(POLL),
                .PAGE_POLLS(PPOLL), .CHIP_POLLS(CPOLL)) u_nor_cmd_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .done(done), .err(err), .xfer_count(xfer_count), .busy(busy), .cs_n(cs_n),
    .bx_start(bx_start), .bx_tx(bx_tx), .bx_done(bx_done), .bx_rx(bx_rx));

  int checks = 0, fails = 0, finished = 0;
  logic [7:0] fb [0:63][0:63];
  int flen [0:63];
  int fst [0:63];
  int fen [0:63];
  int fcnt = 0, busy_left = 0, cyc = 0, stray = 0;
  logic [7:0] wq [0:255];
  logic [7:0] rcv [0:255];
  int rn = 0;
  logic r_err;
  int r_cnt;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Shifter and flash model, driven on the falling edge
  initial begin
    int lat;
    int bi;
    logic csp;
    lat = 0; csp = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      bx_done = 1'b0;
      if (csp && !cs_n && fcnt < 64) begin flen[fcnt] = 0; fst[fcnt] = cyc; end
      if (!csp && cs_n && fcnt < 64) begin fen[fcnt] = cyc; fcnt++; end
      csp = cs_n;
      if (lat > 0) begin lat--; if (lat == 0) bx_done = 1'b1; end
      if (bx_start) begin
        if (cs_n || fcnt >= 64) stray++;
        else begin
          bi = flen[fcnt];
          if (bi < 64) fb[fcnt][bi] = bx_tx;
          flen[fcnt] = bi + 1;
          if (bi == 1 && fb[fcnt][0] == 8'h05) begin
            if (busy_left > 0) begin busy_left--; bx_rx = 8'h03; end
            else bx_rx = 8'h02;
          end else bx_rx = 8'hA0 ^ bi[7:0];
        end
        lat = 2;
      end
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000 && finished == 0) begin @(posedge clk); wd++; end
    if (finished == 0) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [23:0] a, input int len,
                        input int bl, input bit stray_req);
    int k, wi;
    bit took;
    fcnt = 0; busy_left = bl; rn = 0; wi = 0; took = 0; k = 0;
    for (int i = 0; i < 256; i++) wq[i] = 8'($urandom);
    do @(negedge clk); while (!req_ready);
    req_op = op; req_addr = a; req_len = LEN_W'(len); req_valid = 1'b1;
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 1) req_valid = 1'b0;
      if (stray_req) begin
        if (k == 2) begin req_valid = 1'b1; req_op = 3'd3; req_addr = 24'h0; end
        if (k == 3) check("R11 req_ready low while busy", req_ready, 0);
        if (k == 4) check("R11 busy high during op", busy, 1);
        if (k == 5) req_valid = 1'b0;
      end
      if (took) wi++;
      wr_valid = (wi < len);
      wr_data = wq[wi & 255];
      took = wr_valid && wr_ready;
      rd_ready = ($urandom % 4) != 0;
      if (rd_valid && rd_ready && rn < 256) begin rcv[rn] = rd_data; rn++; end
      if (done) break;
    end
    wr_valid = 1'b0;
    r_err = err; r_cnt = int'(xfer_count);
  endtask

  task automatic chk_gaps(input string tag);
    for (int f = 1; f < fcnt; f++)
      check({tag, " R10 cs high gap ok"}, int'(fst[f] - fen[f-1] >= GAP), 1);
    check({tag, " R10 no byte outside frame"}, stray, 0);
  endtask

  task automatic chk_head(input string tag, input int f, input logic [7:0] opc,
                          input bit with_addr, input logic [23:0] a);
    check({tag, " opcode"}, fb[f][0], opc);
    if (with_addr) begin
      check({tag, " addr hi"}, fb[f][1], a[23:16]);
      check({tag, " addr mid"}, fb[f][2], a[15:8]);
      check({tag, " addr lo"}, fb[f][3], a[7:0]);
    end
  endtask

  function automatic int prog_len(input logic [23:0] a, input int len);
    int room;
    room = 256 - int'(a[7:0]);
    return (len > room) ? room : len;
  endfunction

  function automatic int sreg_len(input logic [23:0] a, input int len);
    return (int'(a[7:0]) + len > 255) ? 255 - int'(a[7:0]) : len;
  endfunction

  task automatic t_read(input logic [23:0] a, input int len, input bit sr);
    run_op(3'd0, a, len, 0, sr);
    check("R2 frame count", fcnt, 1);
    check("R2 frame length", flen[0], 4 + len);
    chk_head("R2", 0, 8'h03, 1, a);
    for (int i = 0; i < len; i++) begin
      check("R2 filler byte", fb[0][4+i], 8'h00);
      check("R2 read data", rcv[i], 8'hA0 ^ 8'(4 + i));
    end
    check("R2 bytes delivered", rn, len);
    check("R2 count", r_cnt, len);
    check("R2 err", r_err, 0);
    chk_gaps("R2");
  endtask

  task automatic t_prog(input logic [23:0] a, input int len, input int bl);
    int n;
    n = prog_len(a, len);
    run_op(3'd1, a, len, bl, 0);
    check("R3 frame count", fcnt, 3 + bl);
    check("R3 wren alone", flen[0], 1);
    check("R3 wren byte", fb[0][0], 8'h06);
    check("R3 settle gap ok", int'(fst[1] - fen[0] >= SETTLE), 1);
    check("R3 program frame length", flen[1], 4 + n);
    chk_head("R3", 1, 8'h02, 1, a);
    for (int i = 0; i < n; i++) check("R3 program data", fb[1][4+i], wq[i]);
    for (int f = 2; f < fcnt; f++) begin
      check("R5 status frame length", flen[f], 2);
      check("R5 status opcode", fb[f][0], 8'h05);
      check("R5 status dummy", fb[f][1], 8'h00);
      check("R5 poll interval ok", int'(fst[f] - fen[f-1] >= POLL), 1);
    end
    check("R3 count clipped", r_cnt, n);
    check("R5 err", r_err, 0);
    chk_gaps("R3");
  endtask

  task automatic t_sreg(input logic [23:0] a, input int len);
    int n;
    n = sreg_len(a, len);
    run_op(3'd4, a, len, 0, 0);
    check("R7 frame count", fcnt, 1);
    check("R7 frame length", flen[0], 5 + n);
    chk_head("R7", 0, 8'h48, 1, a);
    check("R7 dummy byte", fb[0][4], 8'h00);
    for (int i = 0; i < n; i++) check("R7 read data", rcv[i], 8'hA0 ^ 8'(5 + i));
    check("R7 bytes delivered", rn, n);
    check("R7 count", r_cnt, n);
    check("R7 err", r_err, 0);
  endtask

  task automatic t_reject(input logic [2:0] op, input logic [23:0] a, input string tag);
    run_op(op, a, 8, 0, 0);
    check({tag, " no frame"}, fcnt, 0);
    check({tag, " err"}, r_err, 1);
    check({tag, " count"}, r_cnt, 0);
  endtask

  initial begin
    void'($urandom(32'd5077));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cs_n", cs_n, 1);
    check("R1 req_ready", req_ready, 1);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 rd_valid", rd_valid, 0);
    check("R1 bx_start", bx_start, 0);

    t_read(24'h12345A, 5, 1'b1);            // R2 with stray request, R11
    for (int r = 0; r < 4; r++) t_read(24'($urandom), 1 + $urandom % 12, 1'b0);

    t_prog(24'h0000FC, 8, 2);               // R3 clip, R5 polling
    t_prog(24'h000F00, 6, 0);
    for (int r = 0; r < 3; r++)
      t_prog({16'($urandom), 8'(240 + $urandom % 16)}, 1 + $urandom % 20, $urandom % 3);

    // R4 sector erase
    run_op(3'd2, 24'h045000, 0, 1, 0);
    check("R4 frame count", fcnt, 4);
    check("R4 wren byte", fb[0][0], 8'h06);
    check("R4 sector frame length", flen[1], 4);
    chk_head("R4", 1, 8'h20, 1, 24'h045000);
    check("R4 err", r_err, 0);
    chk_gaps("R4");
    // R4 chip erase
    run_op(3'd3, 24'h0, 0, 3, 0);
    check("R4 chip frame count", fcnt, 6);
    check("R4 chip frame length", flen[1], 1);
    check("R4 chip opcode", fb[1][0], 8'hC7);
    check("R4 chip err", r_err, 0);

    // R6 timeouts
    run_op(3'd1, 24'h000100, 3, 100, 0);
    check("R6 program polls", fcnt, 2 + PPOLL);
    check("R6 program err", r_err, 1);
    run_op(3'd2, 24'h001000, 0, 100, 0);
    check("R6 sector polls", fcnt, 2 + PPOLL);
    check("R6 sector err", r_err, 1);
    run_op(3'd3, 24'h0, 0, 100, 0);
    check("R6 chip polls", fcnt, 2 + CPOLL);
    check("R6 chip err", r_err, 1);

    // R7 security register reads
    t_sreg(24'h001010, 8);
    t_sreg(24'h0020F8, 20);
    t_sreg(24'h0030FF, 4);
    for (int r = 0; r < 3; r++)
      t_sreg({10'd0, 2'(1 + $urandom % 3), 4'd0, 8'($urandom)}, 1 + $urandom % 16);

    // R8 window rejects
    t_reject(3'd4, 24'h000010, "R8 window zero");
    t_reject(3'd4, 24'h001100, "R8 offset high");
    t_reject(3'd4, 24'h005010, "R8 upper bits");
    // R12 invalid code
    t_reject(3'd7, 24'h000000, "R12 invalid op");

    // R9 power commands
    run_op(3'd5, 24'h0, 0, 0, 0);
    check("R9 sleep frames", fcnt, 1);
    check("R9 sleep length", flen[0], 1);
    check("R9 sleep byte", fb[0][0], 8'hB9);
    run_op(3'd6, 24'h0, 0, 0, 0);
    check("R9 wake frames", fcnt, 1);
    check("R9 wake length", flen[0], 1);
    check("R9 wake byte", fb[0][0], 8'hAB);
    check("R9 err", r_err, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule